// File: doc/BRIEF.md
# Host-DSP IPC Doorbell Register File

This block holds the registers that a host CPU and a DSP use to pass short messages to each other. There are two channels. On the outbound channel the host posts a message word and an extension word for the DSP. Posting the message word with its busy flag set sends a one-cycle doorbell pulse to the DSP. The DSP later signals acceptance, which clears busy and raises a done flag for the host. On the inbound channel the DSP loads a message and an extension word with one strobe. The host clears the busy flag by writing 1 to it, then writes 0 to the pending flag to tell the DSP that the message has been handled.

The host side is a single-cycle register bus: a write enable, an address and write data, with read data decoded combinationally from the address. A control register holds separate interrupt enables for inbound busy and for outbound done. The level interrupt to the host is the OR of each flag ANDed with its enable. The host must not post a new message while the previous one is still busy. If it tries, the write is dropped and a sticky error bit records the attempt. Bit 31 of a message word is its busy flag and bits 30:0 are the message field. Bit 29 of that field is the reply/notification direction bit, which the block stores and returns unchanged.

Register offsets: 0 outbound message, 1 outbound extension, 2 outbound acknowledge (done at bit 30), 3 inbound message, 4 inbound extension, 5 inbound acknowledge (pending at bit 31), 6 control (bit 0 busy enable, bit 1 done enable, bit 2 sticky error).

Top module: `ipc_doorbell_regs`

## Requirements
- R1: After reset every register reads 0, `hst_irq` and `dsp_doorbell` are low, and `dsp_in_free` is high.
- R2: Writing offset 0 with bit 31 set while it is not busy stores bits 30:0 and sets busy. `dsp_doorbell` is then high for exactly the one cycle after the write. A write to offset 1 while not busy is stored and driven on `dsp_out_ext`.
- R3: Writing offset 0 with bit 31 clear while it is not busy stores bits 30:0 only: busy stays clear and no doorbell is sent.
- R4: While outbound busy is set, writes to offsets 0 and 1 change nothing. A write to offset 0 with bit 31 set in that state sets control bit 2. Writing 1 to control bit 2 clears it.
- R5: `dsp_accept` while outbound busy clears busy and sets done (offset 2, bit 30). `dsp_accept` while not busy has no effect.
- R6: Writing 1 to offset 2 bit 30 clears done, even if the rest of the word is unchanged. Writing 0 there leaves done set.
- R7: `dsp_load` while `dsp_in_free` is high stores `{1, dsp_in_msg}` at offset 3 and `dsp_in_ext` at offset 4, and sets pending (offset 5, bit 31). `dsp_in_free` is high only while both inbound busy and pending are clear, and a load while it is low is ignored.
- R8: Writing 1 to offset 3 bit 31 clears inbound busy and keeps the message field. Writing 0 there has no effect.
- R9: Writing offset 5 with bit 31 clear while pending clears pending and gives a one-cycle `dsp_in_done` pulse in the following cycle. Writing 1 there has no effect.
- R10: `hst_irq` equals (inbound busy AND control bit 0) OR (done AND control bit 1). Clearing an enable drops the interrupt while the flag stays set.
- R11: When `dsp_accept` and a host write clearing done fall in the same cycle, done ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_we | input | 1 | Host write enable |
| hst_addr | input | ADDR_W | Host register offset |
| hst_wdata | input | DATA_W | Host write data |
| hst_rdata | output | DATA_W | Host read data for `hst_addr` |
| hst_irq | output | 1 | Level interrupt to the host |
| dsp_doorbell | output | 1 | One-cycle pulse: new outbound message |
| dsp_out_msg | output | DATA_W-1 | Outbound message field |
| dsp_out_ext | output | DATA_W | Outbound extension word |
| dsp_accept | input | 1 | DSP has taken the outbound message |
| dsp_load | input | 1 | DSP loads an inbound message |
| dsp_in_msg | input | DATA_W-1 | Inbound message field |
| dsp_in_ext | input | DATA_W | Inbound extension word |
| dsp_in_free | output | 1 | Inbound channel can take a load |
| dsp_in_done | output | 1 | One-cycle pulse: host finished the inbound message |

## Verification
The message path is driven with message words both with and without the busy flag. This separates storing the message field from launching a doorbell. Writes and loads are repeated while the channel is occupied, to show that they are dropped rather than overwriting the pending message, and the sticky error shows which of them were counted as protocol violations. Each status flag is tested with the clearing polarity and with the opposite one (write 1 versus write 0), so that a clear that fires on the wrong value is caught. Both interrupt enables are toggled while their flags stay set, which tells a masking fault apart from a flag fault. Same-cycle collisions between a DSP strobe and a host clear settle which side wins.

// File: rtl/ipc_dbl_pkg.sv
package ipc_dbl_pkg;
   // Register offsets on the host bus
   localparam int unsigned OFS_OREQ = 0;
   localparam int unsigned OFS_OEXT = 1;
   localparam int unsigned OFS_OACK = 2;
   localparam int unsigned OFS_IREQ = 3;
   localparam int unsigned OFS_IEXT = 4;
   localparam int unsigned OFS_IACK = 5;
   localparam int unsigned OFS_CTRL = 6;
   // Control register bit positions
   localparam int unsigned CTL_BUSY_IE = 0;
   localparam int unsigned CTL_DONE_IE = 1;
   localparam int unsigned CTL_ERR     = 2;
   localparam int unsigned CTL_W       = 3;

   typedef struct packed {
      logic oreq;
      logic oext;
      logic oack;
      logic ireq;
      logic iack;
      logic ctrl;
   } wr_hit_t;
endpackage

// File: rtl/ipc_tx_chan.sv
module ipc_tx_chan #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned DONE_BIT = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic              wr_ext,
   input  logic              wr_ack,
   input  logic [DATA_W-1:0] wdata,
   input  logic              dsp_accept,
   output logic              busy,
   output logic [DATA_W-2:0] msg,
   output logic [DATA_W-1:0] ext,
   output logic              done,
   output logic              doorbell,
   output logic              err_set
);
   localparam int unsigned MSB = DATA_W - 1;

   logic take;
   assign take    = dsp_accept & busy;
   assign err_set = wr_req & busy & wdata[MSB];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         msg      <= '0;
         doorbell <= 1'b0;
      end else begin
         doorbell <= 1'b0;
         if (take) begin
            busy <= 1'b0;
         end else if (wr_req && !busy) begin
            msg      <= wdata[MSB-1:0];
            busy     <= wdata[MSB];
            doorbell <= wdata[MSB];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ext <= '0;
      else if (wr_ext && !busy) ext <= wdata;
   end

   // Acceptance wins over a same-cycle host clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          done <= 1'b0;
      else if (take)                       done <= 1'b1;
      else if (wr_ack && wdata[DONE_BIT])  done <= 1'b0;
   end
endmodule

// File: rtl/ipc_rx_chan.sv
module ipc_rx_chan #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic              wr_ack,
   input  logic [DATA_W-1:0] wdata,
   input  logic              dsp_load,
   input  logic [DATA_W-2:0] dsp_msg,
   input  logic [DATA_W-1:0] dsp_ext,
   output logic              busy,
   output logic [DATA_W-2:0] msg,
   output logic [DATA_W-1:0] ext,
   output logic              pend,
   output logic              free,
   output logic              done_pulse
);
   localparam int unsigned MSB = DATA_W - 1;

   logic fin;
   assign free = ~busy & ~pend;
   assign fin  = wr_ack & ~wdata[MSB] & pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         pend       <= 1'b0;
         msg        <= '0;
         ext        <= '0;
         done_pulse <= 1'b0;
      end else begin
         done_pulse <= fin;
         if (dsp_load && free) begin
            busy <= 1'b1;
            pend <= 1'b1;
            msg  <= dsp_msg;
            ext  <= dsp_ext;
         end else begin
            if (wr_req && wdata[MSB]) busy <= 1'b0;
            if (fin)                  pend <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/ipc_irq_ctl.sv
module ipc_irq_ctl
   import ipc_dbl_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic [DATA_W-1:0] wdata,
   input  logic              err_set,
   input  logic              in_busy,
   input  logic              out_done,
   output logic              busy_ie,
   output logic              done_ie,
   output logic              err,
   output logic              irq
);
   logic irq_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_ie <= 1'b0;
         done_ie <= 1'b0;
      end else if (wr_ctrl) begin
         busy_ie <= wdata[CTL_BUSY_IE];
         done_ie <= wdata[CTL_DONE_IE];
      end
   end

   // A new violation wins over a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          err <= 1'b0;
      else if (err_set)                    err <= 1'b1;
      else if (wr_ctrl && wdata[CTL_ERR])  err <= 1'b0;
   end

   assign irq_d = (in_busy & busy_ie) | (out_done & done_ie);

   generate
      if (IRQ_REG) begin : g_irq_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= irq_d;
         end
      end else begin : g_irq_comb
         assign irq = irq_d;
      end
   endgenerate
endmodule

// File: rtl/ipc_doorbell_regs.sv
module ipc_doorbell_regs
   import ipc_dbl_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned DONE_BIT = 30,
   parameter bit          IRQ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_we,
   input  logic [ADDR_W-1:0] hst_addr,
   input  logic [DATA_W-1:0] hst_wdata,
   output logic [DATA_W-1:0] hst_rdata,
   output logic              hst_irq,
   output logic              dsp_doorbell,
   output logic [DATA_W-2:0] dsp_out_msg,
   output logic [DATA_W-1:0] dsp_out_ext,
   input  logic              dsp_accept,
   input  logic              dsp_load,
   input  logic [DATA_W-2:0] dsp_in_msg,
   input  logic [DATA_W-1:0] dsp_in_ext,
   output logic              dsp_in_free,
   output logic              dsp_in_done
);
   localparam int unsigned MSB = DATA_W - 1;

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("DATA_W must be at least 8");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must cover seven registers");
      end
      if (DONE_BIT >= DATA_W) begin : g_bad_done
         $error("DONE_BIT outside the data word");
      end
   endgenerate

   wr_hit_t hit;
   always_comb begin
      hit.oreq = hst_we && (hst_addr == ADDR_W'(OFS_OREQ));
      hit.oext = hst_we && (hst_addr == ADDR_W'(OFS_OEXT));
      hit.oack = hst_we && (hst_addr == ADDR_W'(OFS_OACK));
      hit.ireq = hst_we && (hst_addr == ADDR_W'(OFS_IREQ));
      hit.iack = hst_we && (hst_addr == ADDR_W'(OFS_IACK));
      hit.ctrl = hst_we && (hst_addr == ADDR_W'(OFS_CTRL));
   end

   logic              tx_busy, tx_done, tx_err_set;
   logic [DATA_W-2:0] tx_msg;
   logic [DATA_W-1:0] tx_ext;
   logic              rx_busy, rx_pend;
   logic [DATA_W-2:0] rx_msg;
   logic [DATA_W-1:0] rx_ext;
   logic              ie_busy, ie_done, err_flg;

   ipc_tx_chan #(.DATA_W(DATA_W), .DONE_BIT(DONE_BIT)) i_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_req     (hit.oreq),
      .wr_ext     (hit.oext),
      .wr_ack     (hit.oack),
      .wdata      (hst_wdata),
      .dsp_accept (dsp_accept),
      .busy       (tx_busy),
      .msg        (tx_msg),
      .ext        (tx_ext),
      .done       (tx_done),
      .doorbell   (dsp_doorbell),
      .err_set    (tx_err_set)
   );

   ipc_rx_chan #(.DATA_W(DATA_W)) i_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_req     (hit.ireq),
      .wr_ack     (hit.iack),
      .wdata      (hst_wdata),
      .dsp_load   (dsp_load),
      .dsp_msg    (dsp_in_msg),
      .dsp_ext    (dsp_in_ext),
      .busy       (rx_busy),
      .msg        (rx_msg),
      .ext        (rx_ext),
      .pend       (rx_pend),
      .free       (dsp_in_free),
      .done_pulse (dsp_in_done)
   );

   ipc_irq_ctl #(.DATA_W(DATA_W), .IRQ_REG(IRQ_REG)) i_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctrl  (hit.ctrl),
      .wdata    (hst_wdata),
      .err_set  (tx_err_set),
      .in_busy  (rx_busy),
      .out_done (tx_done),
      .busy_ie  (ie_busy),
      .done_ie  (ie_done),
      .err      (err_flg),
      .irq      (hst_irq)
   );

   assign dsp_out_msg = tx_msg;
   assign dsp_out_ext = tx_ext;

   logic [DATA_W-1:0] oack_w, iack_w, ctrl_w;
   always_comb begin
      oack_w           = '0;
      oack_w[DONE_BIT] = tx_done;
      iack_w           = '0;
      iack_w[MSB]      = rx_pend;
      ctrl_w              = '0;
      ctrl_w[CTL_BUSY_IE] = ie_busy;
      ctrl_w[CTL_DONE_IE] = ie_done;
      ctrl_w[CTL_ERR]     = err_flg;
   end

   always_comb begin
      hst_rdata = '0;
      case (hst_addr)
         ADDR_W'(OFS_OREQ): hst_rdata = {tx_busy, tx_msg};
         ADDR_W'(OFS_OEXT): hst_rdata = tx_ext;
         ADDR_W'(OFS_OACK): hst_rdata = oack_w;
         ADDR_W'(OFS_IREQ): hst_rdata = {rx_busy, rx_msg};
         ADDR_W'(OFS_IEXT): hst_rdata = rx_ext;
         ADDR_W'(OFS_IACK): hst_rdata = iack_w;
         ADDR_W'(OFS_CTRL): hst_rdata = ctrl_w;
         default:           hst_rdata = '0;
      endcase
   end
endmodule

// File: rtl/ipc_doorbell_chk.sv
module ipc_doorbell_chk #(
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hst_irq,
   input logic              dsp_doorbell,
   input logic [DATA_W-1:0] dsp_out_ext,
   input logic              dsp_accept,
   input logic              dsp_load,
   input logic              dsp_in_free,
   input logic              dsp_in_done,
   input logic              tx_busy,
   input logic              tx_done,
   input logic              rx_busy,
   input logic              rx_pend,
   input logic [DATA_W-1:0] rx_ext
);
   // R2: doorbell lasts one cycle and only accompanies a busy message
   p_doorbell_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dsp_doorbell |=> !dsp_doorbell);
   p_doorbell_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dsp_doorbell |-> tx_busy);
   // R4: extension frozen while the message is outstanding
   p_ext_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_busy && $past(tx_busy)) |-> $stable(dsp_out_ext));
   // R5: acceptance of a busy message raises done and frees the channel
   p_accept_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_accept && tx_busy) |=> (tx_done && !tx_busy));
   // R7: a load that is not allowed leaves the stored extension alone
   p_load_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_load && !dsp_in_free) |=> $stable(rx_ext));
   // R9: the finish pulse comes with pending already clear
   p_in_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dsp_in_done |-> !rx_pend);
   // R10: no interrupt without a raised flag
   p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_busy && !tx_done) |-> !hst_irq);
endmodule

bind ipc_doorbell_regs ipc_doorbell_chk #(.DATA_W(DATA_W)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .hst_irq      (hst_irq),
   .dsp_doorbell (dsp_doorbell),
   .dsp_out_ext  (dsp_out_ext),
   .dsp_accept   (dsp_accept),
   .dsp_load     (dsp_load),
   .dsp_in_free  (dsp_in_free),
   .dsp_in_done  (dsp_in_done),
   .tx_busy      (tx_busy),
   .tx_done      (tx_done),
   .rx_busy      (rx_busy),
   .rx_pend      (rx_pend),
   .rx_ext       (rx_ext)
);

// File: tb/test_ipc_doorbell_regs.sv
module test_ipc_doorbell_regs;
   localparam int unsigned DW = 32;
   localparam int unsigned AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hst_we = 1'b0;
   logic [AW-1:0] hst_addr = '0;
   logic [DW-1:0] hst_wdata = '0;
   logic [DW-1:0] hst_rdata;
   logic          hst_irq, dsp_doorbell, dsp_in_free, dsp_in_done;
   logic [DW-2:0] dsp_out_msg;
   logic [DW-1:0] dsp_out_ext;
   logic          dsp_accept = 1'b0, dsp_load = 1'b0;
   logic [DW-2:0] dsp_in_msg = '0;
   logic [DW-1:0] dsp_in_ext = '0;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   ipc_doorbell_regs i_ipc_doorbell_regs (
      .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_addr(hst_addr),
      .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_irq(hst_irq),
      .dsp_doorbell(dsp_doorbell), .dsp_out_msg(dsp_out_msg),
      .dsp_out_ext(dsp_out_ext), .dsp_accept(dsp_accept), .dsp_load(dsp_load),
      .dsp_in_msg(dsp_in_msg), .dsp_in_ext(dsp_in_ext),
      .dsp_in_free(dsp_in_free), .dsp_in_done(dsp_in_done));

   // op: 0 host write, 1 DSP load, 2 DSP accept, 3 idle
   typedef struct packed {
      logic [1:0]  op;
      logic [2:0]  wa;
      logic [31:0] d;
      logic [2:0]  ca;
      logic [31:0] e;
      logic        ei;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t TAB [NV] = '{
      '{2'd0, 3'd6, 32'h0000_0003, 3'd6, 32'h0000_0003, 1'b0, 4'd10}, // R10 enables
      '{2'd0, 3'd1, 32'hA5A5_0001, 3'd1, 32'hA5A5_0001, 1'b0, 4'd2},  // R2 ext
      '{2'd0, 3'd0, 32'h0000_0123, 3'd0, 32'h0000_0123, 1'b0, 4'd3},  // R3 no busy
      '{2'd0, 3'd0, 32'hA000_0456, 3'd0, 32'hA000_0456, 1'b0, 4'd2},  // R2 post
      '{2'd0, 3'd1, 32'h1111_1111, 3'd1, 32'hA5A5_0001, 1'b0, 4'd4},  // R4 ext held
      '{2'd0, 3'd0, 32'h8000_0777, 3'd0, 32'hA000_0456, 1'b0, 4'd4},  // R4 req held
      '{2'd3, 3'd0, 32'h0,         3'd6, 32'h0000_0007, 1'b0, 4'd4},  // R4 error
      '{2'd0, 3'd6, 32'h0000_0007, 3'd6, 32'h0000_0003, 1'b0, 4'd4},  // R4 clear
      '{2'd2, 3'd0, 32'h0,         3'd2, 32'h4000_0000, 1'b1, 4'd5},  // R5 accept
      '{2'd2, 3'd0, 32'h0,         3'd0, 32'h2000_0456, 1'b1, 4'd5},  // R5 idle accept
      '{2'd0, 3'd6, 32'h0000_0001, 3'd2, 32'h4000_0000, 1'b0, 4'd10}, // R10 mask done
      '{2'd0, 3'd2, 32'h0000_0000, 3'd2, 32'h4000_0000, 1'b0, 4'd6},  // R6 write 0
      '{2'd0, 3'd2, 32'h4000_0000, 3'd2, 32'h0000_0000, 1'b0, 4'd6},  // R6 write 1
      '{2'd0, 3'd6, 32'h0000_0003, 3'd6, 32'h0000_0003, 1'b0, 4'd10}, // R10
      '{2'd1, 3'd0, 32'h2000_0042, 3'd3, 32'hA000_0042, 1'b1, 4'd7},  // R7 load
      '{2'd3, 3'd0, 32'h0,         3'd4, 32'h0042_2000, 1'b1, 4'd7},  // R7 ext
      '{2'd3, 3'd0, 32'h0,         3'd5, 32'h8000_0000, 1'b1, 4'd7},  // R7 pending
      '{2'd1, 3'd0, 32'h0000_0055, 3'd3, 32'hA000_0042, 1'b1, 4'd7},  // R7 not free
      '{2'd0, 3'd3, 32'h0000_0000, 3'd3, 32'hA000_0042, 1'b1, 4'd8},  // R8 write 0
      '{2'd0, 3'd3, 32'h8000_0000, 3'd3, 32'h2000_0042, 1'b0, 4'd8},  // R8 write 1
      '{2'd0, 3'd5, 32'h8000_0000, 3'd5, 32'h8000_0000, 1'b0, 4'd9},  // R9 write 1
      '{2'd0, 3'd5, 32'h0000_0000, 3'd5, 32'h0000_0000, 1'b0, 4'd9}   // R9 write 0
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] op, input logic [2:0] wa, input logic [31:0] d);
      case (op)
         2'd0: begin hst_we = 1'b1; hst_addr = wa; hst_wdata = d; end
         2'd1: begin dsp_load = 1'b1; dsp_in_msg = d[30:0]; dsp_in_ext = {d[15:0], d[31:16]}; end
         2'd2: dsp_accept = 1'b1;
         default: ;
      endcase
   endtask

   task automatic finish_cycle();
      @(posedge clk); #1;
      hst_we = 1'b0; dsp_load = 1'b0; dsp_accept = 1'b0;
   endtask

   task automatic step(input logic [1:0] op, input logic [2:0] wa, input logic [31:0] d);
      drive(op, wa, d);
      finish_cycle();
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      hst_addr = a; #0.5; v = hst_rdata;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(5.0 * 100000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      // R1: reset state
      for (int a = 0; a < 7; a++) begin
         rd(3'(a), v);
         check($sformatf("R1 reg %0d", a), v, 32'h0);
      end
      check("R1 irq", {31'h0, hst_irq}, 32'h0);
      check("R1 doorbell", {31'h0, dsp_doorbell}, 32'h0);
      check("R1 in_free", {31'h0, dsp_in_free}, 32'h1);

      for (int i = 0; i < NV; i++) begin
         step(TAB[i].op, TAB[i].wa, TAB[i].d);
         rd(TAB[i].ca, v);
         check($sformatf("R%0d vec %0d", TAB[i].rq, i), v, TAB[i].e);
         check($sformatf("R10 irq vec %0d", i), {31'h0, hst_irq}, {31'h0, TAB[i].ei});
      end

      // R2: doorbell timing and extension on the DSP side
      step(2'd0, 3'd0, 32'h8000_0001);
      check("R2 doorbell high", {31'h0, dsp_doorbell}, 32'h1);
      check("R2 out_msg", {1'b0, dsp_out_msg}, 32'h0000_0001);
      check("R2 out_ext", dsp_out_ext, 32'hA5A5_0001);
      step(2'd3, 3'd0, 32'h0);
      check("R2 doorbell low", {31'h0, dsp_doorbell}, 32'h0);

      // R11: accept collides with a host clear of done
      step(2'd2, 3'd0, 32'h0);
      step(2'd0, 3'd0, 32'h8000_0002);
      drive(2'd0, 3'd2, 32'h4000_0000);
      drive(2'd2, 3'd0, 32'h0);
      finish_cycle();
      rd(3'd2, v);
      check("R11 done survives", v, 32'h4000_0000);
      rd(3'd0, v);
      check("R5 busy cleared", v, 32'h0000_0002);
      step(2'd0, 3'd2, 32'h4000_0000);

      // R7 / R9: free and finish pulse
      step(2'd1, 3'd0, 32'h0000_0011);
      check("R7 not free after load", {31'h0, dsp_in_free}, 32'h0);
      step(2'd0, 3'd3, 32'h8000_0000);
      check("R7 not free while pending", {31'h0, dsp_in_free}, 32'h0);
      step(2'd0, 3'd5, 32'h0);
      check("R9 done pulse", {31'h0, dsp_in_done}, 32'h1);
      check("R9 free again", {31'h0, dsp_in_free}, 32'h1);
      step(2'd3, 3'd0, 32'h0);
      check("R9 pulse ends", {31'h0, dsp_in_done}, 32'h0);

      summary();
   end
endmodule